// File: doc/BRIEF.md
# Read-Only Line Classifier

This block holds a few bits of classification state for every line of a shared second-level cache. Its job is to decide when a line may be copied into the private first-level caches. The lines it allows are those that have gone unwritten for a long enough time. The block keeps no tags and no data. The surrounding cache controller tells it which line index is being filled, evicted, read or written. In reply it learns, one cycle after each read, whether the requesting core may install the line in its private cache.

Each line has three pieces of state: a two-bit age counter, a "handed out" flag and a "modified" flag. That is four bits per line, whatever the number of cores. A free-running period timer sends one aging pulse every `AGE_PERIOD` cycles, and the pulse steps every counter down towards zero. A line is read-only when its age is zero and it has never been modified. Sometimes a write reaches a line that has already been handed out. The block does not track which cores hold a copy. It emits a single-cycle broadcast invalidate that carries the line index. After that the line is served only from the shared cache until it is evicted and refilled.

Lines that have never been filled, and lines that have been evicted, are held in a "not present" encoding: age at its maximum and modified set. Such a line can never be granted.

Top module: `ro_line_classifier`

## Requirements
- R1: After reset, and after an eviction, a line is not L1-cacheable. A read to it is answered with `acc_l1ok` = 0.
- R2: A fill loads the line's age with `FILL_AGE` (2) and clears its modified and handed-out flags. A read issued within fewer than `AGE_PERIOD` cycles after the fill is answered with `acc_l1ok` = 0.
- R3: Every `AGE_PERIOD` cycles, all line ages are decremented together. The decrement stops at zero: a read-only line stays grantable however long it stays idle.
- R4: Every read (`acc_vld`) produces exactly one response (`acc_rsp_vld`) on the following cycle. `acc_l1ok` = 1 exactly when the line's age was zero and its modified flag was clear. A granted read sets the line's handed-out flag.
- R5: A write always sets the line's modified flag. A line that is written before it reaches age zero is never granted until it is evicted and refilled.
- R6: A write to a line whose handed-out flag is set drives `inv_vld` high for exactly one cycle, on the cycle after the write, with `inv_idx` equal to the written index. It also clears the flag, and later reads of that line are refused.
- R7: A write to a line that has not been handed out produces no invalidate. `inv_vld` never rises without a write on the previous cycle.
- R8: After an eviction, a refill starts the classification again from the beginning: the line is refused right after the refill and granted again only after aging back to zero.
- R9: A read and a write to the same line in the same cycle: the write takes effect and the read is refused (`acc_l1ok` = 0). A fill or eviction of the read's line in that same cycle also refuses the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_vld | input | 1 | A line is being installed in the shared cache |
| fill_idx | input | IDX_W | Index of the installed line |
| evict_vld | input | 1 | A line is leaving the shared cache |
| evict_idx | input | IDX_W | Index of the evicted line |
| acc_vld | input | 1 | Read request from a core |
| acc_idx | input | IDX_W | Index of the read line |
| wr_vld | input | 1 | Write request from a core |
| wr_idx | input | IDX_W | Index of the written line |
| acc_rsp_vld | output | 1 | Response to the read of the previous cycle |
| acc_l1ok | output | 1 | The read line may be installed in the requesting core's L1 |
| inv_vld | output | 1 | Single-cycle broadcast invalidate |
| inv_idx | output | IDX_W | Line index carried by the invalidate |

## Verification
The bench goes after the age window, reading right after a fill and again after two full periods. A design that loaded the wrong fill value, or aged on every cycle, would grant too early or too late. It idles a granted line for many periods to catch a counter that wraps from zero back to its maximum and so withdraws a grant. It issues writes to handed-out lines and to lines never handed out, back to back, to catch missing, stretched or spurious invalidate pulses and wrong indices. It also hits the same line with a read and a write in one cycle, and refills after an eviction, to catch stale grants and classification that survives an eviction.

// File: rtl/ro_cls_pkg.sv
package ro_cls_pkg;
  // Width of the per-line age counter.
  parameter int AGE_W = 2;

  typedef struct packed {
    logic [AGE_W-1:0] age;
    logic             handed;   // copy may live in some L1
    logic             modified; // written since fill, or not present
  } line_meta_t;

  localparam int META_BITS = $bits(line_meta_t);
endpackage

// File: rtl/ro_age_timer.sv
module ro_age_timer #(
  parameter int AGE_PERIOD = 8,
  localparam int CNT_W = (AGE_PERIOD > 1) ? $clog2(AGE_PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(AGE_PERIOD - 1));
  assign tick   = at_end;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (at_end) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ro_line_slot.sv
module ro_line_slot
  import ro_cls_pkg::*;
#(
  parameter int FILL_AGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       evict_hit,
  input  logic       fill_hit,
  input  logic       wr_hit,
  input  logic       grant_hit,
  output line_meta_t meta
);
  line_meta_t meta_q, meta_d;

  always_comb begin
    meta_d = meta_q;
    if (evict_hit) begin
      meta_d.age      = '1;
      meta_d.handed   = 1'b0;
      meta_d.modified = 1'b1;
    end else if (fill_hit) begin
      meta_d.age      = AGE_W'(FILL_AGE);
      meta_d.handed   = 1'b0;
      meta_d.modified = 1'b0;
    end else begin
      // Write is applied before the aging step of the same cycle.
      if (wr_hit) begin
        meta_d.modified = 1'b1;
        meta_d.handed   = 1'b0;
      end else if (grant_hit) begin
        meta_d.handed   = 1'b1;
      end
      if (tick && (meta_d.age != '0)) meta_d.age = meta_d.age - AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q.age      <= '1;
      meta_q.handed   <= 1'b0;
      meta_q.modified <= 1'b1;
    end else begin
      meta_q <= meta_d;
    end
  end

  assign meta = meta_q;
endmodule

// File: rtl/ro_access_resolver.sv
module ro_access_resolver
  import ro_cls_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  line_meta_t [LINES-1:0] meta_i,
  input  logic                   acc_vld,
  input  logic [IDX_W-1:0]       acc_idx,
  input  logic                   wr_vld,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   fill_vld,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic                   evict_vld,
  input  logic [IDX_W-1:0]       evict_idx,
  output logic                   grant_vld,
  output logic                   acc_rsp_vld,
  output logic                   acc_l1ok,
  output logic                   inv_vld,
  output logic [IDX_W-1:0]       inv_idx
);
  line_meta_t       acc_meta, wr_meta;
  logic             ro_line, clash, grant_d, inv_d;
  logic             rsp_q, ok_q, inv_q;
  logic [IDX_W-1:0] inv_idx_q;

  assign acc_meta = meta_i[acc_idx];
  assign wr_meta  = meta_i[wr_idx];
  assign ro_line  = (acc_meta.age == '0) && !acc_meta.modified;
  assign clash    = (wr_vld && wr_idx == acc_idx) ||
                    (fill_vld && fill_idx == acc_idx) ||
                    (evict_vld && evict_idx == acc_idx);
  assign grant_d  = acc_vld && ro_line && !clash;
  assign inv_d    = wr_vld && wr_meta.handed &&
                    !(evict_vld && evict_idx == wr_idx) &&
                    !(fill_vld && fill_idx == wr_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
      ok_q  <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      rsp_q <= acc_vld;
      ok_q  <= grant_d;
      inv_q <= inv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     inv_idx_q <= '0;
    else if (inv_d) inv_idx_q <= wr_idx;
  end

  assign grant_vld   = grant_d;
  assign acc_rsp_vld = rsp_q;
  assign acc_l1ok    = ok_q;
  assign inv_vld     = inv_q;
  assign inv_idx     = inv_idx_q;
endmodule

// File: rtl/ro_line_classifier.sv
module ro_line_classifier
  import ro_cls_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int AGE_PERIOD = 8,
  parameter int FILL_AGE   = 2,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             evict_vld,
  input  logic [IDX_W-1:0] evict_idx,
  input  logic             acc_vld,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             acc_rsp_vld,
  output logic             acc_l1ok,
  output logic             inv_vld,
  output logic [IDX_W-1:0] inv_idx
);
  logic                   age_tick;
  logic                   grant_vld;
  line_meta_t [LINES-1:0] meta;

  ro_age_timer #(.AGE_PERIOD(AGE_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(age_tick)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic ev_h, fl_h, wr_h, gr_h;
    assign ev_h = evict_vld && (evict_idx == IDX_W'(g));
    assign fl_h = fill_vld  && (fill_idx  == IDX_W'(g));
    assign wr_h = wr_vld    && (wr_idx    == IDX_W'(g));
    assign gr_h = grant_vld && (acc_idx   == IDX_W'(g));

    ro_line_slot #(.FILL_AGE(FILL_AGE)) u_slot (
      .clk(clk), .rst_n(rst_n), .tick(age_tick),
      .evict_hit(ev_h), .fill_hit(fl_h), .wr_hit(wr_h), .grant_hit(gr_h),
      .meta(meta[g])
    );
  end

  ro_access_resolver #(.LINES(LINES)) u_resolve (
    .clk(clk), .rst_n(rst_n), .meta_i(meta),
    .acc_vld(acc_vld), .acc_idx(acc_idx),
    .wr_vld(wr_vld), .wr_idx(wr_idx),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .evict_vld(evict_vld), .evict_idx(evict_idx),
    .grant_vld(grant_vld),
    .acc_rsp_vld(acc_rsp_vld), .acc_l1ok(acc_l1ok),
    .inv_vld(inv_vld), .inv_idx(inv_idx)
  );
endmodule

// File: rtl/ro_cls_checker.sv
module ro_cls_checker #(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_vld,
  input logic [IDX_W-1:0] fill_idx,
  input logic             evict_vld,
  input logic [IDX_W-1:0] evict_idx,
  input logic             acc_vld,
  input logic [IDX_W-1:0] acc_idx,
  input logic             wr_vld,
  input logic [IDX_W-1:0] wr_idx,
  input logic             acc_rsp_vld,
  input logic             acc_l1ok,
  input logic             inv_vld,
  input logic [IDX_W-1:0] inv_idx
);
  // Shadow bits kept from the ports: present since fill, written since fill.
  logic [LINES-1:0] present_q, written_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
      written_q <= '0;
    end else begin
      if (wr_vld)    written_q[wr_idx] <= 1'b1;
      if (fill_vld) begin
        present_q[fill_idx] <= 1'b1;
        written_q[fill_idx] <= 1'b0;
      end
      if (evict_vld) present_q[evict_idx] <= 1'b0;
    end
  end

  p_absent_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !present_q[acc_idx] |=> !acc_l1ok);

  p_fresh_fill_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && $past(fill_vld) && ($past(fill_idx) == acc_idx) |=> !acc_l1ok);

  p_one_response_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> acc_rsp_vld);

  p_grant_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_l1ok |-> acc_rsp_vld);

  p_written_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && written_q[acc_idx] |=> !acc_l1ok);

  p_inv_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |-> $past(wr_vld) && ($past(wr_idx) == inv_idx));

  p_no_inv_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> !inv_vld);

  p_same_cycle_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && wr_vld && (acc_idx == wr_idx) |=> !acc_l1ok);
endmodule

bind ro_line_classifier ro_cls_checker #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fill_vld(fill_vld), .fill_idx(fill_idx),
  .evict_vld(evict_vld), .evict_idx(evict_idx),
  .acc_vld(acc_vld), .acc_idx(acc_idx),
  .wr_vld(wr_vld), .wr_idx(wr_idx),
  .acc_rsp_vld(acc_rsp_vld), .acc_l1ok(acc_l1ok),
  .inv_vld(inv_vld), .inv_idx(inv_idx)
);

// File: tb/tb_ro_line_classifier.sv
`timescale 1ns/1ps
module tb_ro_line_classifier;
  localparam int LINES = 16;
  localparam int N     = 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int SETTLE = 2 * N + 4; // at least two aging pulses

  logic clk, rst_n;
  logic fill_vld, evict_vld, acc_vld, wr_vld;
  logic [IDX_W-1:0] fill_idx, evict_idx, acc_idx, wr_idx;
  logic acc_rsp_vld, acc_l1ok, inv_vld;
  logic [IDX_W-1:0] inv_idx;

  int n_cmp, n_bad, cycles;
  bit done;
  int exp_ok_q[$], exp_ok_tag[$], exp_inv_q[$], exp_inv_tag[$];

  ro_line_classifier #(.LINES(LINES), .AGE_PERIOD(N), .FILL_AGE(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .evict_vld(evict_vld), .evict_idx(evict_idx),
    .acc_vld(acc_vld), .acc_idx(acc_idx),
    .wr_vld(wr_vld), .wr_idx(wr_idx),
    .acc_rsp_vld(acc_rsp_vld), .acc_l1ok(acc_l1ok),
    .inv_vld(inv_vld), .inv_idx(inv_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expected items as the design produces results.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (acc_rsp_vld) begin
        if (exp_ok_q.size() == 0) check("R4 unexpected response", 1, 0);
        else check($sformatf("R%0d grant", exp_ok_tag.pop_front()),
                   int'(acc_l1ok), exp_ok_q.pop_front());
      end
      if (inv_vld) begin
        if (exp_inv_q.size() == 0) check("R7 unexpected invalidate", int'(inv_idx), -1);
        else check($sformatf("R%0d inv index", exp_inv_tag.pop_front()),
                   int'(inv_idx), exp_inv_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      check("watchdog expired", 1, 0);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_fill(input int idx);
    @(negedge clk); fill_vld = 1'b1; fill_idx = IDX_W'(idx);
    @(negedge clk); fill_vld = 1'b0;
  endtask

  task automatic do_evict(input int idx);
    @(negedge clk); evict_vld = 1'b1; evict_idx = IDX_W'(idx);
    @(negedge clk); evict_vld = 1'b0;
  endtask

  // Driver: queue the expected answer, then issue the read.
  task automatic do_read(input int idx, input int exp, input int tag);
    @(negedge clk);
    exp_ok_q.push_back(exp); exp_ok_tag.push_back(tag);
    acc_vld = 1'b1; acc_idx = IDX_W'(idx);
    @(negedge clk); acc_vld = 1'b0;
  endtask

  task automatic do_write(input int idx, input bit exp_inv, input int tag);
    @(negedge clk);
    if (exp_inv) begin exp_inv_q.push_back(idx); exp_inv_tag.push_back(tag); end
    wr_vld = 1'b1; wr_idx = IDX_W'(idx);
    @(negedge clk); wr_vld = 1'b0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cycles = 0; done = 1'b0;
    fill_vld = 0; evict_vld = 0; acc_vld = 0; wr_vld = 0;
    fill_idx = '0; evict_idx = '0; acc_idx = '0; wr_idx = '0;
    rst_n = 1'b0;
    idle(3);
    check("R1 reset rsp_vld", int'(acc_rsp_vld), 0);
    check("R1 reset inv_vld", int'(inv_vld), 0);
    rst_n = 1'b1;
    idle(2);

    do_read(3, 0, 1);                 // R1: never filled
    idle(SETTLE);
    do_read(3, 0, 1);                 // R1: absent line does not age into a grant

    do_fill(1);
    do_read(1, 0, 2);                 // R2: right after fill
    idle(3);
    do_read(1, 0, 2);                 // R2: still inside one period
    idle(SETTLE);
    do_read(1, 1, 3);                 // R3/R4: aged to zero
    do_read(1, 1, 4);                 // R4: repeated grant
    idle(6 * N);
    do_read(1, 1, 3);                 // R3: saturates at zero

    do_write(1, 1'b1, 6);             // R6: handed-out line invalidated
    do_read(1, 0, 6);
    idle(SETTLE);
    do_read(1, 0, 6);                 // R6: stays L2-only
    do_write(1, 1'b0, 7);             // R7: no second invalidate

    do_fill(2);
    do_write(2, 1'b0, 7);             // R7: never handed out
    idle(4 * N);
    do_read(2, 0, 5);                 // R5: dirty blocks classification

    do_fill(4);
    idle(SETTLE);
    do_read(4, 1, 8);
    do_evict(4);
    do_read(4, 0, 8);                 // R8: evicted
    do_write(4, 1'b0, 8);             // R8: handed-out flag dropped by evict
    do_fill(4);
    do_read(4, 0, 8);                 // R8: restarts
    idle(SETTLE);
    do_read(4, 1, 8);                 // R8: granted again after aging

    do_fill(5);
    idle(SETTLE);
    @(negedge clk);                   // R9: read and write in the same cycle
    exp_ok_q.push_back(0); exp_ok_tag.push_back(9);
    acc_vld = 1'b1; acc_idx = IDX_W'(5);
    wr_vld  = 1'b1; wr_idx  = IDX_W'(5);
    @(negedge clk); acc_vld = 1'b0; wr_vld = 1'b0;
    do_write(5, 1'b0, 9);             // R9: refused read left nothing handed out
    do_read(5, 0, 9);

    do_fill(6);
    do_fill(7);
    idle(SETTLE);
    do_read(6, 1, 4);
    do_read(7, 1, 4);
    @(negedge clk);                   // R6: back-to-back invalidates
    exp_inv_q.push_back(6); exp_inv_tag.push_back(6);
    wr_vld = 1'b1; wr_idx = IDX_W'(6);
    @(negedge clk);
    exp_inv_q.push_back(7); exp_inv_tag.push_back(6);
    wr_idx = IDX_W'(7);
    @(negedge clk); wr_vld = 1'b0;

    idle(4);
    check("R4 all responses seen", exp_ok_q.size(), 0);
    check("R6 all invalidates seen", exp_inv_q.size(), 0);
    finish_run();
  end
endmodule